// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits (4 by default) and returns a two's-complement product of `2*WIDTH` bits. It takes several cycles and performs exactly one add step for each multiplier bit. It keeps a running partial sum one bit wider than the operands and sign-extends it at every step, so the multiplicand keeps its signed value. The step for the multiplier's sign bit is different: when that bit is set, the step adds the negated multiplicand instead of the multiplicand. This produces the signed result with no extra correction cycle.

The block accepts a new pair of operands on a single-cycle `start_i` pulse when it is idle. It then asserts `busy_o` while it works through the multiplier bits, starting from the least significant bit. When the last step completes, it raises `done_o` for one cycle and presents the result on `product_o`. The result stays on `product_o` until the next operation completes.

Top module: `signed_seq_mult`

## Requirements
- R1: After reset is asserted, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` pulse sampled while `busy_o` is 0 captures `a_i` and `b_i`, and `busy_o` is 1 from the next cycle.
- R3: `busy_o` stays at 1 for exactly `WIDTH` cycles. In the cycle after the last of them, `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R4: When `done_o` is 1, `product_o` equals the signed product of the captured operands as a `2*WIDTH`-bit two's-complement value, for every operand pair.
- R5: A negative multiplier is handled inside the final step. With `WIDTH`=4, A=-6 and B=-3 give 8'h12 (18), and A=5 with B=-1 gives 8'hFB (-5).
- R6: The most negative operand times itself is exact. With `WIDTH`=4, -8 times -8 gives 8'h40 (64).
- R7: A `start_i` sampled while `busy_o` is 1 has no effect. The running operation keeps its operands and its completion cycle.
- R8: `product_o` holds its value from the cycle `done_o` rises until the next operation completes, including while a later operation is busy.
- R9: A zero operand on either side gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; acted on only when idle |
| a_i | input | WIDTH | Multiplicand, two's complement |
| b_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | High while add steps are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
Every one of the 256 operand pairs for `WIDTH`=4 is applied. This exercises every combination of signs for the multiplicand and the multiplier. A wrong sign extension shows up with a negative multiplicand. A missing or misplaced correction shows up only when the multiplier is negative. The pair -8 times -8 separates an N+1-bit partial sum from one that is too narrow. Back-to-back starts, a start issued during a busy operation and long idle gaps separate correct handshake timing from early acceptance, and a held product from one that drifts.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int unsigned DEF_WIDTH = 4;

  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one add-shift step
    logic last;   // current step handles the multiplier sign bit
  } smul_ctl_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output smul_ctl_t ctl_o,
  output logic      busy_o,
  output logic      done_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic          load, last;

  assign load = start_i & ~busy_q;
  assign last = busy_q & (cnt_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign ctl_o.load = load;
  assign ctl_o.step = busy_q;
  assign ctl_o.last = last;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  // R3: completion is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R3: busy only drops together with a completion
  a_r3_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  // R7: a start during busy neither restarts nor stops the run
  a_r7_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST_IDX));
endmodule

// File: rtl/smul_addend.sv
module smul_addend #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic [WIDTH:0]   addend_o
);
  logic [WIDTH:0] a_ext;
  assign a_ext = {a_i[WIDTH-1], a_i};

  // sign step: (WIDTH+1)-bit two's complement of A replaces A
  always_comb begin
    if (!bit_i)      addend_o = '0;
    else if (last_i) addend_o = ~a_ext + {{WIDTH{1'b0}}, 1'b1};
    else             addend_o = a_ext;
  end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  smul_ctl_t          ctl_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH:0]   hi_q, hi_d, addend, sum;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic [PW-1:0]    prod_q;

  smul_addend #(.WIDTH(WIDTH)) u_addend (
    .a_i      (mcand_q),
    .bit_i    (lo_q[0]),
    .last_i   (ctl_i.last),
    .addend_o (addend)
  );

  // carry beyond the top bit is dropped
  assign sum  = hi_q + addend;
  assign hi_d = {sum[WIDTH], sum[WIDTH:1]};
  assign lo_d = {sum[0], lo_q[WIDTH-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      prod_q  <= '0;
    end else if (ctl_i.load) begin
      mcand_q <= a_i;
      hi_q    <= '0;
      lo_q    <= b_i;
    end else if (ctl_i.step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      if (ctl_i.last) prod_q <= {hi_d[WIDTH-1:0], lo_d};
    end
  end

  assign product_o = prod_q;

  // R8: result changes only on a final step
  a_r8_prod_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_i.step && ctl_i.last) |=> $stable(prod_q));
  // R7: operands stay captured through a run
  a_r7_mcand_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.step && !ctl_i.load) |=> $stable(mcand_q));
endmodule

// File: rtl/signed_seq_mult.sv
module signed_seq_mult
  import smul_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  smul_ctl_t ctl;

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ctl_o   (ctl),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  smul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl),
    .a_i       (a_i),
    .b_i       (b_i),
    .product_o (product_o)
  );

  // R2: an accepted start raises busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/signed_seq_mult_test.sv
module signed_seq_mult_test;
  localparam int W = 4;
  localparam int PW = 2 * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  signed_seq_mult #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  // behavioural reference
  int m_cnt = 0;
  bit m_busy = 0, m_done = 0;
  int m_a = 0, m_b = 0;
  logic [PW-1:0] m_prod = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_done = 0; m_prod = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == W) begin
          m_busy = 0; m_done = 1;
          m_prod = PW'(m_a * m_b);
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        m_a = int'($signed(a)); m_b = int'($signed(b));
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      n_chk++;
      if (busy !== m_busy || done !== m_done || product !== m_prod) begin
        n_bad++;
        $display("FAIL %s: busy/done/product actual %b/%b/%h expected %b/%b/%h",
                 cur_req, busy, done, product, m_busy, m_done, m_prod);
      end
    end
  end

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start at a negedge, return at the negedge where done is visible
  task automatic run(input logic [W-1:0] ai, input logic [W-1:0] bi);
    a = ai; b = bi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (W) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {6'b0, busy, done}, '0);
    check("R1", product, '0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R2 accept and busy next cycle
    cur_req = "R2";
    a = 4'd3; b = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {7'b0, busy}, 8'd1);
    repeat (W) @(negedge clk);
    check("R3", {6'b0, busy, done}, 8'b01);
    check("R4", product, 8'd6);
    @(negedge clk);
    check("R3", {7'b0, done}, 8'd0);

    // R5 negative multiplier
    cur_req = "R5";
    run(4'b1010, 4'b1101);
    check("R5", product, 8'h12);
    run(4'd5, 4'b1111);
    check("R5", product, 8'hFB);

    // R6 most negative squared
    cur_req = "R6";
    run(4'b1000, 4'b1000);
    check("R6", product, 8'h40);

    // R9 zero operands
    cur_req = "R9";
    run(4'b0000, 4'b1000);
    check("R9", product, 8'h00);
    run(4'b0111, 4'b0000);
    check("R9", product, 8'h00);

    // R7 start during busy ignored
    cur_req = "R7";
    a = 4'd7; b = 4'd7; start = 1'b1;
    @(negedge clk);
    a = 4'b1001; b = 4'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (W - 1) @(negedge clk);
    check("R7", {7'b0, done}, 8'd1);
    check("R7", product, 8'd49);

    // R8 hold while idle and during next busy period
    cur_req = "R8";
    repeat (5) @(negedge clk);
    check("R8", product, 8'd49);
    a = 4'd2; b = 4'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8", product, 8'd49);
    repeat (W - 1) @(negedge clk);
    check("R8", product, 8'd4);

    // R4 exhaustive, back to back
    cur_req = "R4";
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        run(W'(i), W'(j));
        check("R4", product, PW'(int'($signed(W'(i))) * int'($signed(W'(j)))));
      end
    end

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule